// File: doc/BRIEF.md
# Layered Fixed-Point Instruction Decoder

This block turns one 32-bit fixed-point instruction word into a flat control record for the execution back end. The record names the execution unit, the encoding form, the internal operation, what feeds each of the three operand slots, where the result goes, how the condition-record bit is chosen, the memory access length, the carry-in source, whether a carry-out must be written, and whether operand A is inverted. The group covered is add, subtract, multiply-immediate, compare and bitwise logic.

Matching runs in three levels. The major table looks at the six most significant bits of the word. For most opcodes that gives a leaf row directly. For the extended group it hands off to a minor table that matches a 9-bit arithmetic slice first and then the full 10-bit slice. A final level checks sub-patterns in reserved fields, and a row that fails there is treated as unmatched. The chosen record is captured in one register stage together with valid and illegal flags.

Top module: `idec_top`

## Requirements
- R1: While rst_n is low, out_valid and out_illegal are 0 and every record field is 0 (the default record: no unit, no form, no operation, all selects none, carry-in zero, carry-out 0, invert 0).
- R2: out_valid equals in_valid from one clock earlier. A cycle with in_valid low gives out_illegal 0 and the default record on the next cycle.
- R3: The major opcode is in_word[31:26]. Codes 14 and 15 give an ALU add in form D with operand 1 = A-or-zero, operand 2 = signed immediate (shifted-high for 15), destination T, no record bit. Code 7 gives a MUL-unit multiply with A and the signed immediate into T.
- R4: Code 12 gives an ALU add of A and the signed immediate into T with carry-out set. Code 13 does the same and also forces the record bit on. Code 8 gives a subtract from the signed immediate with A inverted, carry-in one and carry-out set.
- R5: Code 11 gives a signed compare of A with the signed immediate, and code 10 an unsigned compare of A with the unsigned immediate. Both are ALU, form D, with the destination the condition field.
- R6: Codes 24/25 (OR), 26/27 (XOR) and 28/29 (AND) give LOGIC-unit rows in form D with operand 1 = S, destination A, and operand 2 the unsigned immediate (shifted-high for the odd codes). Only the AND codes force the record bit on.
- R7: Under major code 31, the slice in_word[9:1] selects form XO arithmetic whatever in_word[10] holds. 266 is add (A, B into T, carry-in zero). 40 is subtract (A inverted, carry-in one). 104 is negate (A only, inverted, carry-in one). All three take the record bit from the instruction field.
- R8: Under major code 31, when no XO row matches, the slice in_word[10:1] selects LOGIC rows in form X with operand 1 = S, operand 2 = B, destination A and the record bit from the field: 28 AND, 444 OR, 316 XOR, 476 NAND, 124 NOR, 284 EQV, 60 AND-complement, 412 OR-complement.
- R9: Under major code 31, slice in_word[10:1] equal to 0 gives a signed register compare and 32 an unsigned one. Both are ALU, form X, A and B into the condition field, no record bit.
- R10: Negate is legal only when in_word[15:11] is zero. The four compare rows (codes 10 and 11, extended 0 and 32) are legal only when in_word[22] is zero.
- R11: A valid word that matches no leaf, or fails R10, gives out_illegal 1 with out_valid 1 and the default record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Record valid, one cycle after input |
| out_illegal | output | 1 | Word matched no leaf row |
| out_unit | output | 2 | Execution unit: 0 none, 1 ALU, 2 LOGIC, 3 MUL |
| out_form | output | 2 | Encoding form: 0 none, 1 D, 2 X, 3 XO |
| out_op | output | 4 | Internal operation code |
| out_in1 | output | 2 | Operand 1 source |
| out_in2 | output | 3 | Operand 2 source |
| out_in3 | output | 1 | Operand 3 source |
| out_dst | output | 2 | Destination select |
| out_rc | output | 2 | Record-bit select: none, forced, from field |
| out_ls_len | output | 3 | Memory access length (none in this group) |
| out_cin | output | 2 | Carry-in source |
| out_cout | output | 1 | Carry-out must be written |
| out_inv_a | output | 1 | Operand A is inverted |

## Verification
Every result, including the illegal flag and the idle default, appears exactly one rising edge after the word is presented. The bench drives a new word on each falling edge and, on that same falling edge, first compares the outputs against the word it drove one cycle earlier. This keeps the stream back to back with no gaps and never samples at the edge. The major opcode space is swept in full with the reserved bit toggled, and the 10-bit extended slice is swept in full with both legal and violating sub-pattern fields. Idle cycles are mixed in to check the default record.

// File: rtl/idec_pkg.sv
package idec_pkg;

   typedef enum logic [1:0] {FU_NONE = 2'd0, FU_ALU, FU_LOGIC, FU_MUL} fu_e;
   typedef enum logic [1:0] {FM_NONE = 2'd0, FM_D, FM_X, FM_XO} form_e;
   typedef enum logic [3:0] {
      OP_NONE = 4'd0, OP_ADD, OP_SUBF, OP_NEG, OP_MUL, OP_CMP, OP_CMPL,
      OP_AND, OP_OR, OP_XOR, OP_NAND, OP_NOR, OP_EQV, OP_ANDC, OP_ORC
   } op_e;
   typedef enum logic [1:0] {I1_NONE = 2'd0, I1_A, I1_A0, I1_S} in1_e;
   typedef enum logic [2:0] {
      I2_NONE = 3'd0, I2_B, I2_SIMM, I2_SIMM_HI, I2_UIMM, I2_UIMM_HI
   } in2_e;
   typedef enum logic [0:0] {I3_NONE = 1'b0, I3_S} in3_e;
   typedef enum logic [1:0] {DS_NONE = 2'd0, DS_T, DS_A, DS_CR} dst_e;
   typedef enum logic [1:0] {RC_NONE = 2'd0, RC_ONE, RC_FIELD} rc_e;
   typedef enum logic [2:0] {LS_NONE = 3'd0, LS_1, LS_2, LS_4, LS_8} lsl_e;
   typedef enum logic [1:0] {CI_ZERO = 2'd0, CI_ONE, CI_CARRY} cin_e;

   typedef struct packed {
      fu_e   unit;
      form_e form;
      op_e   op;
      in1_e  in1;
      in2_e  in2;
      in3_e  in3;
      dst_e  dst;
      rc_e   rc;
      lsl_e  lsl;
      cin_e  cin;
      logic  cout;
      logic  inv_a;
   } ctl_t;

   localparam ctl_t CTL_DEFAULT = ctl_t'('0);

   // major opcode values
   localparam int PO_MULI    = 7;
   localparam int PO_SUBI_C  = 8;
   localparam int PO_CMPLI   = 10;
   localparam int PO_CMPI    = 11;
   localparam int PO_ADDI_C  = 12;
   localparam int PO_ADDI_CR = 13;
   localparam int PO_ADDI    = 14;
   localparam int PO_ADDIS   = 15;
   localparam int PO_ORI     = 24;
   localparam int PO_ORIS    = 25;
   localparam int PO_XORI    = 26;
   localparam int PO_XORIS   = 27;
   localparam int PO_ANDI    = 28;
   localparam int PO_ANDIS   = 29;
   localparam int PO_EXT     = 31;

   // 9-bit arithmetic slice values
   localparam int XO_ADD  = 266;
   localparam int XO_SUBF = 40;
   localparam int XO_NEG  = 104;

   // 10-bit slice values
   localparam int XX_CMP  = 0;
   localparam int XX_CMPL = 32;
   localparam int XX_AND  = 28;
   localparam int XX_OR   = 444;
   localparam int XX_XOR  = 316;
   localparam int XX_NAND = 476;
   localparam int XX_NOR  = 124;
   localparam int XX_EQV  = 284;
   localparam int XX_ANDC = 60;
   localparam int XX_ORC  = 412;

   function automatic ctl_t mk_row(fu_e u, form_e f, op_e o, in1_e a, in2_e b,
                                   dst_e d, rc_e r, cin_e c, logic co, logic inv);
      ctl_t x;
      x       = CTL_DEFAULT;
      x.unit  = u;
      x.form  = f;
      x.op    = o;
      x.in1   = a;
      x.in2   = b;
      x.in3   = I3_NONE;
      x.dst   = d;
      x.rc    = r;
      x.lsl   = LS_NONE;
      x.cin   = c;
      x.cout  = co;
      x.inv_a = inv;
      return x;
   endfunction

endpackage

// File: rtl/idec_major.sv
module idec_major
   import idec_pkg::*;
#(
   parameter int PRI_W    = 6,
   parameter int EXT_CODE = PO_EXT
) (
   input  logic [PRI_W-1:0] pri,
   output ctl_t             row,
   output logic             hit,
   output logic             to_ext,
   output logic             need_l0
);

   always_comb begin
      row     = CTL_DEFAULT;
      hit     = 1'b1;
      to_ext  = 1'b0;
      need_l0 = 1'b0;
      case (int'(pri))
         PO_ADDI:    row = mk_row(FU_ALU, FM_D, OP_ADD, I1_A0, I2_SIMM, DS_T, RC_NONE, CI_ZERO, 1'b0, 1'b0);
         PO_ADDIS:   row = mk_row(FU_ALU, FM_D, OP_ADD, I1_A0, I2_SIMM_HI, DS_T, RC_NONE, CI_ZERO, 1'b0, 1'b0);
         PO_MULI:    row = mk_row(FU_MUL, FM_D, OP_MUL, I1_A, I2_SIMM, DS_T, RC_NONE, CI_ZERO, 1'b0, 1'b0);
         PO_ADDI_C:  row = mk_row(FU_ALU, FM_D, OP_ADD, I1_A, I2_SIMM, DS_T, RC_NONE, CI_ZERO, 1'b1, 1'b0);
         PO_ADDI_CR: row = mk_row(FU_ALU, FM_D, OP_ADD, I1_A, I2_SIMM, DS_T, RC_ONE, CI_ZERO, 1'b1, 1'b0);
         PO_SUBI_C:  row = mk_row(FU_ALU, FM_D, OP_SUBF, I1_A, I2_SIMM, DS_T, RC_NONE, CI_ONE, 1'b1, 1'b1);
         PO_CMPI: begin
            row     = mk_row(FU_ALU, FM_D, OP_CMP, I1_A, I2_SIMM, DS_CR, RC_NONE, CI_ZERO, 1'b0, 1'b0);
            need_l0 = 1'b1;
         end
         PO_CMPLI: begin
            row     = mk_row(FU_ALU, FM_D, OP_CMPL, I1_A, I2_UIMM, DS_CR, RC_NONE, CI_ZERO, 1'b0, 1'b0);
            need_l0 = 1'b1;
         end
         PO_ORI:   row = mk_row(FU_LOGIC, FM_D, OP_OR,  I1_S, I2_UIMM,    DS_A, RC_NONE, CI_ZERO, 1'b0, 1'b0);
         PO_ORIS:  row = mk_row(FU_LOGIC, FM_D, OP_OR,  I1_S, I2_UIMM_HI, DS_A, RC_NONE, CI_ZERO, 1'b0, 1'b0);
         PO_XORI:  row = mk_row(FU_LOGIC, FM_D, OP_XOR, I1_S, I2_UIMM,    DS_A, RC_NONE, CI_ZERO, 1'b0, 1'b0);
         PO_XORIS: row = mk_row(FU_LOGIC, FM_D, OP_XOR, I1_S, I2_UIMM_HI, DS_A, RC_NONE, CI_ZERO, 1'b0, 1'b0);
         PO_ANDI:  row = mk_row(FU_LOGIC, FM_D, OP_AND, I1_S, I2_UIMM,    DS_A, RC_ONE,  CI_ZERO, 1'b0, 1'b0);
         PO_ANDIS: row = mk_row(FU_LOGIC, FM_D, OP_AND, I1_S, I2_UIMM_HI, DS_A, RC_ONE,  CI_ZERO, 1'b0, 1'b0);
         default: begin
            if (int'(pri) == EXT_CODE) begin
               to_ext = 1'b1;
            end else begin
               hit = 1'b0;
            end
         end
      endcase
   end

endmodule

// File: rtl/idec_minor.sv
module idec_minor
   import idec_pkg::*;
#(
   parameter int XO_W = 9,
   parameter int X_W  = 10
) (
   input  logic [X_W-1:0] xfield,
   output ctl_t           row,
   output logic           hit,
   output logic           need_rb0,
   output logic           need_l0
);

   ctl_t xo_row;
   logic xo_hit;
   ctl_t x_row;
   logic x_hit;
   logic x_l0;

   // narrower arithmetic slice, overflow-enable bit ignored
   always_comb begin
      xo_row = CTL_DEFAULT;
      xo_hit = 1'b1;
      case (int'(xfield[XO_W-1:0]))
         XO_ADD:  xo_row = mk_row(FU_ALU, FM_XO, OP_ADD,  I1_A, I2_B,    DS_T, RC_FIELD, CI_ZERO, 1'b0, 1'b0);
         XO_SUBF: xo_row = mk_row(FU_ALU, FM_XO, OP_SUBF, I1_A, I2_B,    DS_T, RC_FIELD, CI_ONE,  1'b0, 1'b1);
         XO_NEG:  xo_row = mk_row(FU_ALU, FM_XO, OP_NEG,  I1_A, I2_NONE, DS_T, RC_FIELD, CI_ONE,  1'b0, 1'b1);
         default: xo_hit = 1'b0;
      endcase
   end

   // full slice: compares and logicals
   always_comb begin
      x_row = CTL_DEFAULT;
      x_hit = 1'b1;
      x_l0  = 1'b0;
      case (int'(xfield))
         XX_CMP: begin
            x_row = mk_row(FU_ALU, FM_X, OP_CMP, I1_A, I2_B, DS_CR, RC_NONE, CI_ZERO, 1'b0, 1'b0);
            x_l0  = 1'b1;
         end
         XX_CMPL: begin
            x_row = mk_row(FU_ALU, FM_X, OP_CMPL, I1_A, I2_B, DS_CR, RC_NONE, CI_ZERO, 1'b0, 1'b0);
            x_l0  = 1'b1;
         end
         XX_AND:  x_row = mk_row(FU_LOGIC, FM_X, OP_AND,  I1_S, I2_B, DS_A, RC_FIELD, CI_ZERO, 1'b0, 1'b0);
         XX_OR:   x_row = mk_row(FU_LOGIC, FM_X, OP_OR,   I1_S, I2_B, DS_A, RC_FIELD, CI_ZERO, 1'b0, 1'b0);
         XX_XOR:  x_row = mk_row(FU_LOGIC, FM_X, OP_XOR,  I1_S, I2_B, DS_A, RC_FIELD, CI_ZERO, 1'b0, 1'b0);
         XX_NAND: x_row = mk_row(FU_LOGIC, FM_X, OP_NAND, I1_S, I2_B, DS_A, RC_FIELD, CI_ZERO, 1'b0, 1'b0);
         XX_NOR:  x_row = mk_row(FU_LOGIC, FM_X, OP_NOR,  I1_S, I2_B, DS_A, RC_FIELD, CI_ZERO, 1'b0, 1'b0);
         XX_EQV:  x_row = mk_row(FU_LOGIC, FM_X, OP_EQV,  I1_S, I2_B, DS_A, RC_FIELD, CI_ZERO, 1'b0, 1'b0);
         XX_ANDC: x_row = mk_row(FU_LOGIC, FM_X, OP_ANDC, I1_S, I2_B, DS_A, RC_FIELD, CI_ZERO, 1'b0, 1'b0);
         XX_ORC:  x_row = mk_row(FU_LOGIC, FM_X, OP_ORC,  I1_S, I2_B, DS_A, RC_FIELD, CI_ZERO, 1'b0, 1'b0);
         default: x_hit = 1'b0;
      endcase
   end

   always_comb begin
      if (xo_hit) begin
         row      = xo_row;
         hit      = 1'b1;
         need_rb0 = (xo_row.op == OP_NEG);
         need_l0  = 1'b0;
      end else begin
         row      = x_row;
         hit      = x_hit;
         need_rb0 = 1'b0;
         need_l0  = x_l0;
      end
   end

endmodule

// File: rtl/idec_subpat.sv
module idec_subpat #(
   parameter int RB_W = 5
) (
   input  logic [RB_W-1:0] rb_field,
   input  logic            l_bit,
   input  logic            need_rb0,
   input  logic            need_l0,
   output logic            ok
);

   logic rb_ok;
   logic l_ok;

   assign rb_ok = !need_rb0 || (rb_field == '0);
   assign l_ok  = !need_l0 || !l_bit;
   assign ok    = rb_ok && l_ok;

endmodule

// File: rtl/idec_top.sv
module idec_top
   import idec_pkg::*;
#(
   parameter int INSN_W     = 32,
   parameter int PRI_W      = 6,
   parameter int XO_W       = 9,
   parameter int X_W        = 10,
   parameter int X_LSB      = 1,
   parameter int RB_LSB     = 11,
   parameter int RB_W       = 5,
   parameter int L_BIT      = 22,
   parameter int OUT_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] in_word,
   output logic              out_valid,
   output logic              out_illegal,
   output logic [1:0]        out_unit,
   output logic [1:0]        out_form,
   output logic [3:0]        out_op,
   output logic [1:0]        out_in1,
   output logic [2:0]        out_in2,
   output logic [0:0]        out_in3,
   output logic [1:0]        out_dst,
   output logic [1:0]        out_rc,
   output logic [2:0]        out_ls_len,
   output logic [1:0]        out_cin,
   output logic              out_cout,
   output logic              out_inv_a
);

   localparam int PRI_LSB = INSN_W - PRI_W;

   // elaboration-time parameter checks
   generate
      if (INSN_W != 32) begin : g_bad_width
         $error("idec_top: INSN_W must be 32");
      end
      if (XO_W >= X_W) begin : g_bad_slices
         $error("idec_top: XO_W must be narrower than X_W");
      end
      if (X_LSB + X_W > PRI_LSB) begin : g_bad_xpos
         $error("idec_top: extended slice overlaps major opcode");
      end
      if (OUT_STAGES < 1 || OUT_STAGES > 2) begin : g_bad_stages
         $error("idec_top: OUT_STAGES must be 1 or 2");
      end
   endgenerate

   // level 1
   ctl_t maj_row;
   logic maj_hit;
   logic maj_ext;
   logic maj_l0;

   idec_major #(.PRI_W(PRI_W)) u_major (
      .pri     (in_word[PRI_LSB +: PRI_W]),
      .row     (maj_row),
      .hit     (maj_hit),
      .to_ext  (maj_ext),
      .need_l0 (maj_l0)
   );

   // level 2
   ctl_t min_row;
   logic min_hit;
   logic min_rb0;
   logic min_l0;

   idec_minor #(.XO_W(XO_W), .X_W(X_W)) u_minor (
      .xfield   (in_word[X_LSB +: X_W]),
      .row      (min_row),
      .hit      (min_hit),
      .need_rb0 (min_rb0),
      .need_l0  (min_l0)
   );

   // level 3
   ctl_t sel_row;
   logic sel_hit;
   logic sel_rb0;
   logic sel_l0;
   logic sub_ok;

   always_comb begin
      if (maj_ext) begin
         sel_row = min_row;
         sel_hit = min_hit;
         sel_rb0 = min_rb0;
         sel_l0  = min_l0;
      end else begin
         sel_row = maj_row;
         sel_hit = maj_hit;
         sel_rb0 = 1'b0;
         sel_l0  = maj_l0;
      end
   end

   idec_subpat #(.RB_W(RB_W)) u_subpat (
      .rb_field (in_word[RB_LSB +: RB_W]),
      .l_bit    (in_word[L_BIT]),
      .need_rb0 (sel_rb0),
      .need_l0  (sel_l0),
      .ok       (sub_ok)
   );

   logic legal;
   ctl_t d_ctl;
   logic d_ill;

   assign legal = sel_hit && sub_ok;
   assign d_ctl = (in_valid && legal) ? sel_row : CTL_DEFAULT;
   assign d_ill = in_valid && !legal;

   // output stages
   ctl_t st_ctl [OUT_STAGES+1];
   logic st_vld [OUT_STAGES+1];
   logic st_ill [OUT_STAGES+1];

   assign st_ctl[0] = d_ctl;
   assign st_vld[0] = in_valid;
   assign st_ill[0] = d_ill;

   genvar s;
   generate
      for (s = 0; s < OUT_STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_ctl[s+1] <= CTL_DEFAULT;
               st_vld[s+1] <= 1'b0;
               st_ill[s+1] <= 1'b0;
            end else begin
               st_ctl[s+1] <= st_ctl[s];
               st_vld[s+1] <= st_vld[s];
               st_ill[s+1] <= st_ill[s];
            end
         end
      end
   endgenerate

   ctl_t q;
   assign q           = st_ctl[OUT_STAGES];
   assign out_valid   = st_vld[OUT_STAGES];
   assign out_illegal = st_ill[OUT_STAGES];
   assign out_unit    = q.unit;
   assign out_form    = q.form;
   assign out_op      = q.op;
   assign out_in1     = q.in1;
   assign out_in2     = q.in2;
   assign out_in3     = q.in3;
   assign out_dst     = q.dst;
   assign out_rc      = q.rc;
   assign out_ls_len  = q.lsl;
   assign out_cin     = q.cin;
   assign out_cout    = q.cout;
   assign out_inv_a   = q.inv_a;

endmodule

// File: rtl/idec_checks.sv
module idec_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       out_valid,
   input logic       out_illegal,
   input logic [1:0] out_unit,
   input logic [1:0] out_form,
   input logic [3:0] out_op,
   input logic [1:0] out_rc,
   input logic       out_cout,
   input logic       out_inv_a
);

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && !out_illegal));

   a_r2_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_illegal && out_op == 4'd0));

   a_r11_illegal_default: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (out_valid && out_unit == 2'd0 && out_op == 4'd0 &&
                       out_form == 2'd0 && !out_cout && !out_inv_a));

   a_r7_xo_takes_field: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_form == 2'd3) |-> (out_rc == 2'd2));

   a_r4_cout_only_imm: assert property (@(posedge clk) disable iff (!rst_n)
      out_cout |-> (out_form == 2'd1 && out_unit == 2'd1));

endmodule

bind idec_top idec_checks u_checks (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .out_valid   (out_valid),
   .out_illegal (out_illegal),
   .out_unit    (out_unit),
   .out_form    (out_form),
   .out_op      (out_op),
   .out_rc      (out_rc),
   .out_cout    (out_cout),
   .out_inv_a   (out_inv_a)
);

// File: tb/idec_top_test.sv
`timescale 1ns/1ps
module idec_top_test;
   import idec_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        out_valid, out_illegal, out_cout, out_inv_a;
   logic [1:0]  out_unit, out_form, out_in1, out_dst, out_rc, out_cin;
   logic [3:0]  out_op;
   logic [2:0]  out_in2, out_ls_len;
   logic [0:0]  out_in3;

   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   idec_top uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .out_valid(out_valid), .out_illegal(out_illegal), .out_unit(out_unit),
      .out_form(out_form), .out_op(out_op), .out_in1(out_in1), .out_in2(out_in2),
      .out_in3(out_in3), .out_dst(out_dst), .out_rc(out_rc), .out_ls_len(out_ls_len),
      .out_cin(out_cin), .out_cout(out_cout), .out_inv_a(out_inv_a)
   );

   function automatic ctl_t r(fu_e u, form_e f, op_e o, in1_e a, in2_e b,
                              dst_e d, rc_e rc, cin_e c, logic co, logic inv);
      ctl_t x = ctl_t'('0);
      x.unit = u; x.form = f; x.op = o; x.in1 = a; x.in2 = b; x.dst = d;
      x.rc = rc; x.cin = c; x.cout = co; x.inv_a = inv;
      return x;
   endfunction

   // expected record from the requirements
   function automatic ctl_t model(input logic [31:0] w, output logic ill, output string tag);
      ctl_t e = ctl_t'('0);
      logic ok = 1'b1;
      int p = int'(w[31:26]);
      int s9 = int'(w[9:1]);
      int s10 = int'(w[10:1]);
      tag = "R11";
      case (p)
         14: begin e = r(FU_ALU, FM_D, OP_ADD, I1_A0, I2_SIMM, DS_T, RC_NONE, CI_ZERO, 0, 0); tag = "R3"; end
         15: begin e = r(FU_ALU, FM_D, OP_ADD, I1_A0, I2_SIMM_HI, DS_T, RC_NONE, CI_ZERO, 0, 0); tag = "R3"; end
         7:  begin e = r(FU_MUL, FM_D, OP_MUL, I1_A, I2_SIMM, DS_T, RC_NONE, CI_ZERO, 0, 0); tag = "R3"; end
         12: begin e = r(FU_ALU, FM_D, OP_ADD, I1_A, I2_SIMM, DS_T, RC_NONE, CI_ZERO, 1, 0); tag = "R4"; end
         13: begin e = r(FU_ALU, FM_D, OP_ADD, I1_A, I2_SIMM, DS_T, RC_ONE, CI_ZERO, 1, 0); tag = "R4"; end
         8:  begin e = r(FU_ALU, FM_D, OP_SUBF, I1_A, I2_SIMM, DS_T, RC_NONE, CI_ONE, 1, 1); tag = "R4"; end
         11: begin e = r(FU_ALU, FM_D, OP_CMP, I1_A, I2_SIMM, DS_CR, RC_NONE, CI_ZERO, 0, 0);
                   ok = !w[22]; tag = w[22] ? "R10" : "R5"; end
         10: begin e = r(FU_ALU, FM_D, OP_CMPL, I1_A, I2_UIMM, DS_CR, RC_NONE, CI_ZERO, 0, 0);
                   ok = !w[22]; tag = w[22] ? "R10" : "R5"; end
         24, 25, 26, 27, 28, 29: begin
            op_e o = (p < 26) ? OP_OR : (p < 28) ? OP_XOR : OP_AND;
            e = r(FU_LOGIC, FM_D, o, I1_S, p[0] ? I2_UIMM_HI : I2_UIMM, DS_A,
                  (p >= 28) ? RC_ONE : RC_NONE, CI_ZERO, 0, 0);
            tag = "R6";
         end
         31: begin
            if (s9 == 266) begin
               e = r(FU_ALU, FM_XO, OP_ADD, I1_A, I2_B, DS_T, RC_FIELD, CI_ZERO, 0, 0); tag = "R7";
            end else if (s9 == 40) begin
               e = r(FU_ALU, FM_XO, OP_SUBF, I1_A, I2_B, DS_T, RC_FIELD, CI_ONE, 0, 1); tag = "R7";
            end else if (s9 == 104) begin
               e = r(FU_ALU, FM_XO, OP_NEG, I1_A, I2_NONE, DS_T, RC_FIELD, CI_ONE, 0, 1);
               ok = (w[15:11] == 5'd0); tag = ok ? "R7" : "R10";
            end else if (s10 == 0 || s10 == 32) begin
               e = r(FU_ALU, FM_X, (s10 == 0) ? OP_CMP : OP_CMPL, I1_A, I2_B, DS_CR, RC_NONE, CI_ZERO, 0, 0);
               ok = !w[22]; tag = w[22] ? "R10" : "R9";
            end else begin
               op_e o = OP_NONE;
               case (s10)
                  28: o = OP_AND;   444: o = OP_OR;   316: o = OP_XOR;  476: o = OP_NAND;
                  124: o = OP_NOR;  284: o = OP_EQV;  60: o = OP_ANDC;  412: o = OP_ORC;
                  default: o = OP_NONE;
               endcase
               if (o != OP_NONE) begin
                  e = r(FU_LOGIC, FM_X, o, I1_S, I2_B, DS_A, RC_FIELD, CI_ZERO, 0, 0); tag = "R8";
               end else begin
                  ok = 1'b0;
               end
            end
         end
         default: ok = 1'b0;
      endcase
      ill = !ok;
      if (!ok) e = ctl_t'('0);
      return e;
   endfunction

   function automatic ctl_t actual();
      ctl_t a;
      a.unit = fu_e'(out_unit); a.form = form_e'(out_form); a.op = op_e'(out_op);
      a.in1 = in1_e'(out_in1); a.in2 = in2_e'(out_in2); a.in3 = in3_e'(out_in3);
      a.dst = dst_e'(out_dst); a.rc = rc_e'(out_rc); a.lsl = lsl_e'(out_ls_len);
      a.cin = cin_e'(out_cin); a.cout = out_cout; a.inv_a = out_inv_a;
      return a;
   endfunction

   logic        have_prev = 1'b0;
   logic        prev_v;
   logic [31:0] prev_w;

   task automatic check_prev();
      ctl_t  e;
      logic  ill;
      string tag;
      ctl_t  a = actual();
      if (prev_v) begin
         e = model(prev_w, ill, tag);
      end else begin
         e = ctl_t'('0); ill = 1'b0; tag = "R2";
      end
      n_run++;
      if (out_valid !== prev_v || out_illegal !== ill || a !== e) begin
         n_fail++;
         $display("FAIL %s word=%h v=%0b: actual valid=%0b ill=%0b rec=%h expected valid=%0b ill=%0b rec=%h",
                  tag, prev_w, prev_v, out_valid, out_illegal, a, prev_v, ill, e);
      end
   endtask

   task automatic apply(input logic v, input logic [31:0] w);
      @(negedge clk);
      if (have_prev) check_prev();
      in_valid = v; in_word = w;
      prev_v = v; prev_w = w; have_prev = 1'b1;
   endtask

   initial begin : watchdog
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : stim
      // R1: reset state, with a valid word presented
      in_valid = 1'b1; in_word = {6'd14, 26'h0};
      repeat (3) @(negedge clk);
      n_run++;
      if (out_valid !== 1'b0 || out_illegal !== 1'b0 || actual() !== ctl_t'('0)) begin
         n_fail++;
         $display("FAIL R1: actual valid=%0b ill=%0b rec=%h expected 0 0 0",
                  out_valid, out_illegal, actual());
      end
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R3 R4 R5 R6 R10 R11: every major code, reserved bit toggled
      for (int p = 0; p < 64; p++) begin
         for (int k = 0; k < 4; k++) begin
            logic [25:0] rest = 26'(p * 32'h0001_3A7 + k * 32'h00C5_F1D + 32'h2AB);
            rest[22] = k[0];
            apply(1'b1, {6'(p), rest});
         end
         if (p % 8 == 0) apply(1'b0, 32'hFFFF_FFFF); // R2 idle gap
      end

      // R7 R8 R9 R10 R11: full extended slice under code 31
      for (int x = 0; x < 1024; x++) begin
         apply(1'b1, {6'd31, 5'd5, 5'd4, 5'd0, 10'(x), 1'b0});
         apply(1'b1, {6'd31, 5'd6, 5'd7, 5'd9, 10'(x), 1'b1});
      end

      // R2: idle after activity, then flush
      apply(1'b0, {6'd31, 5'd5, 5'd4, 5'd0, 10'd266, 1'b0});
      apply(1'b1, {6'd13, 26'h3FF_FFFF});
      apply(1'b0, 32'h0);
      apply(1'b0, 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule